// File: doc/BRIEF.md
# Byte-Beat Fill and Blend Datapath

This block is the data stage of a memory-to-memory copy engine. It takes one source beat stream and, when needed, one destination beat stream, and it produces the beats to be written back. Each beat is one byte. Address generation and bus arbitration are done elsewhere. This block only decides which bytes to consume and what value to emit.

There are three modes, and they follow a fixed priority:

- **Constant fill** wins over the other two. It writes bytes of the first 32-bit fill word and reads no input data.
- **Mask-driven fill** comes next. It takes one source byte as an eight-bit mask. Each mask bit then picks the output byte from either the first or the second fill word.
- **Blend** applies when neither fill flag is set. It combines source and destination bytes with one of eight logic operators. The destination stream is read only for operators that use it.

A skip option drops every other group of 1, 2, 4 or 8 source bytes. It works in both blend mode and mask-driven fill.

Software pulses `xfer_start` before each transfer. The pulse restarts the byte-lane counter, discards any partly used mask, and restarts the skip phase.

Top module: `fill_blend_dp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `wr_valid` is 0 and `dst_ready` is 0.
- R2: In blend mode, each written byte is `cfg_op` applied to the next kept source byte s and the next destination byte d. The encodings are: 0 = s, 1 = s&d, 2 = s|d, 3 = s^d, 4 = ~s, 5 = s&~d, 6 = s|~d, 7 = 0. A source byte is consumed for every output byte, including for operators 4 and 7.
- R3: `dst_ready` is asserted only in blend mode with `cfg_op` in {1,2,3,5,6}. It is never asserted in either fill mode, or with `cfg_op` 0, 4 or 7.
- R4: Constant fill (`cfg_fill_simple`=1) writes byte lane L of `fill_one`, meaning bits 8L+7..8L. L counts 0,1,2,3,0,... from the last `xfer_start`. No source byte is consumed.
- R5: When both `cfg_fill_simple` and `cfg_fill_mask` are 1, the block behaves exactly as constant fill.
- R6: Mask-driven fill (`cfg_fill_mask`=1, `cfg_fill_simple`=0) consumes one kept source byte as a mask for every eight output bytes. A mask bit of 1 writes lane L of `fill_one`. A mask bit of 0 writes lane L of `fill_two`. Lanes are counted as in R4.
- R7: In mask-driven fill, `cfg_mask_lsb`=0 uses the mask bits from bit 7 down to bit 0. `cfg_mask_lsb`=1 uses them from bit 0 up to bit 7.
- R8: With `cfg_skip_en`=1, source bytes form groups of N = 2^`cfg_skip_n` bytes counted from `xfer_start`. The first group is kept, the next is dropped, and so on, in both blend and mask-driven fill. Dropped bytes are accepted and never reach the output.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` stays 1 and `wr_data` stays unchanged into the next cycle.
- R10: `xfer_start` resets the lane to 0, empties the mask register, and returns the skip phase to a kept group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle pulse that begins a transfer |
| cfg_op | input | 3 | Blend operator |
| cfg_fill_simple | input | 1 | Constant fill enable |
| cfg_fill_mask | input | 1 | Mask-driven fill enable |
| cfg_mask_lsb | input | 1 | Mask bit order, 1 = bit 0 first |
| cfg_skip_en | input | 1 | Drop alternate source groups |
| cfg_skip_n | input | 2 | Group size exponent |
| fill_one | input | 32 | First fill word |
| fill_two | input | 32 | Second fill word |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Source beat accepted |
| src_data | input | 8 | Source beat |
| dst_valid | input | 1 | Destination beat valid |
| dst_ready | output | 1 | Destination beat accepted |
| dst_data | input | 8 | Destination beat |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_data | output | 8 | Write beat |

## Verification
The assertions assume three things about the inputs:

- All configuration inputs stay constant from one `xfer_start` to the next.
- `xfer_start` arrives only after the write output has drained, and never in the same cycle as a source handshake.
- Upstream raises `src_valid` and `dst_valid` without waiting for a ready, because the ready outputs depend on those valids.

The bench follows these rules. It changes configuration only while the source and destination are idle and `wr_ready` is high, and it pulses `xfer_start` one cycle later. Sources hold valid steadily, and stalls come only from a periodic low on `wr_ready`.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

   typedef enum logic [2:0] {
      OP_COPY  = 3'd0,
      OP_AND   = 3'd1,
      OP_OR    = 3'd2,
      OP_XOR   = 3'd3,
      OP_NOTS  = 3'd4,
      OP_ANDN  = 3'd5,
      OP_ORN   = 3'd6,
      OP_CLEAR = 3'd7
   } blend_op_e;

   function automatic logic op_reads_dst(blend_op_e op);
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN: return 1'b1;
         default:                                return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dfp_skip_gate.sv
module dfp_skip_gate #(
   parameter int BEAT_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              skip_en,
   input  logic [SEL_W-1:0]  skip_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [BEAT_W-1:0] src_data,
   output logic              k_valid,
   input  logic              k_ready,
   output logic [BEAT_W-1:0] k_data
);
   localparam int CNT_W = 1 << SEL_W;

   logic [CNT_W-1:0] grp_cnt;
   logic             drop;

   assign drop      = skip_en && grp_cnt[skip_n];
   assign k_valid   = src_valid && !drop;
   assign k_data    = src_data;
   assign src_ready = drop || k_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     grp_cnt <= '0;
      else if (clear)                                 grp_cnt <= '0;
      else if (skip_en && src_valid && src_ready)     grp_cnt <= grp_cnt + 1'b1;
   end

   // R8
   drop_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && src_valid) |-> (src_ready && !k_valid));
endmodule

// File: rtl/dfp_mask_shift.sv
module dfp_mask_shift #(
   parameter int BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [BEAT_W-1:0] load_data,
   input  logic              shift,
   input  logic              lsb_first,
   output logic              bit_out,
   output logic              empty
);
   localparam int CNT_W = $clog2(BEAT_W + 1);

   logic [BEAT_W-1:0] sr;
   logic [CNT_W-1:0]  left;

   assign empty   = (left == '0);
   assign bit_out = lsb_first ? sr[0] : sr[BEAT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (clear) begin
         left <= '0;
      end else if (load) begin
         sr   <= load_data;
         left <= CNT_W'(BEAT_W);
      end else if (shift) begin
         sr   <= lsb_first ? (sr >> 1) : (sr << 1);
         left <= left - 1'b1;
      end
   end

   // R6
   shift_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !empty);
   // R6
   load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (empty && !shift));
endmodule

// File: rtl/dfp_lane_pick.sv
module dfp_lane_pick #(
   parameter int BEAT_W = 8,
   parameter int FILL_W = 32,
   parameter int LANE_W = 2
) (
   input  logic [FILL_W-1:0] word,
   input  logic [LANE_W-1:0] lane,
   output logic [BEAT_W-1:0] beat
);
   localparam int LANES = FILL_W / BEAT_W;

   logic [BEAT_W-1:0] slice [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign slice[g] = word[g*BEAT_W +: BEAT_W];
   end

   assign beat = slice[lane];
endmodule

// File: rtl/fill_blend_dp.sv
module fill_blend_dp
   import dfp_pkg::*;
#(
   parameter int BEAT_W = 8,
   parameter int FILL_W = 32,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic [2:0]        cfg_op,
   input  logic              cfg_fill_simple,
   input  logic              cfg_fill_mask,
   input  logic              cfg_mask_lsb,
   input  logic              cfg_skip_en,
   input  logic [SEL_W-1:0]  cfg_skip_n,
   input  logic [FILL_W-1:0] fill_one,
   input  logic [FILL_W-1:0] fill_two,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [BEAT_W-1:0] src_data,
   input  logic              dst_valid,
   output logic              dst_ready,
   input  logic [BEAT_W-1:0] dst_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [BEAT_W-1:0] wr_data
);
   localparam int LANES  = FILL_W / BEAT_W;
   localparam int LANE_W = $clog2(LANES);

   if (FILL_W % BEAT_W != 0) begin : g_bad_fill
      $error("FILL_W must be a multiple of BEAT_W");
   end
   if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("FILL_W/BEAT_W must be a power of two of at least 2");
   end

   blend_op_e         op;
   logic              mode_simple, mode_mask, mode_norm, need_dst;
   logic              adv, fire, go_norm;
   logic              k_valid, k_ready;
   logic [BEAT_W-1:0] k_data;
   logic              m_bit, m_empty, m_load, m_shift;
   logic [LANE_W-1:0] lane;
   logic [BEAT_W-1:0] f1_beat, f2_beat, blend, next_val;

   assign op          = blend_op_e'(cfg_op);
   assign mode_simple = cfg_fill_simple;
   assign mode_mask   = !cfg_fill_simple && cfg_fill_mask;
   assign mode_norm   = !cfg_fill_simple && !cfg_fill_mask;
   assign need_dst    = mode_norm && op_reads_dst(op);

   assign adv     = (!wr_valid || wr_ready) && !xfer_start;
   assign go_norm = mode_norm && adv && k_valid && (!need_dst || dst_valid);
   assign m_load  = mode_mask && m_empty && k_valid && !xfer_start;
   assign m_shift = mode_mask && adv && !m_empty;

   always_comb begin
      if (mode_norm)      k_ready = adv && (!need_dst || dst_valid);
      else if (mode_mask) k_ready = m_empty && !xfer_start;
      else                k_ready = 1'b0;
   end

   assign dst_ready = need_dst && adv && k_valid;
   assign fire      = mode_simple ? adv : (mode_mask ? m_shift : go_norm);

   dfp_skip_gate #(.BEAT_W(BEAT_W), .SEL_W(SEL_W)) u_skip (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start),
      .skip_en(cfg_skip_en && !mode_simple), .skip_n(cfg_skip_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .k_valid(k_valid), .k_ready(k_ready), .k_data(k_data)
   );

   dfp_mask_shift #(.BEAT_W(BEAT_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start),
      .load(m_load), .load_data(k_data), .shift(m_shift),
      .lsb_first(cfg_mask_lsb), .bit_out(m_bit), .empty(m_empty)
   );

   dfp_lane_pick #(.BEAT_W(BEAT_W), .FILL_W(FILL_W), .LANE_W(LANE_W)) u_pick1 (
      .word(fill_one), .lane(lane), .beat(f1_beat)
   );
   dfp_lane_pick #(.BEAT_W(BEAT_W), .FILL_W(FILL_W), .LANE_W(LANE_W)) u_pick2 (
      .word(fill_two), .lane(lane), .beat(f2_beat)
   );

   always_comb begin
      case (op)
         OP_COPY:  blend = k_data;
         OP_AND:   blend = k_data & dst_data;
         OP_OR:    blend = k_data | dst_data;
         OP_XOR:   blend = k_data ^ dst_data;
         OP_NOTS:  blend = ~k_data;
         OP_ANDN:  blend = k_data & ~dst_data;
         OP_ORN:   blend = k_data | ~dst_data;
         default:  blend = '0;
      endcase
   end

   always_comb begin
      if (mode_simple)    next_val = f1_beat;
      else if (mode_mask) next_val = m_bit ? f1_beat : f2_beat;
      else                next_val = blend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_data  <= '0;
         lane     <= '0;
      end else begin
         if (fire) begin
            wr_valid <= 1'b1;
            wr_data  <= next_val;
         end else if (wr_ready) begin
            wr_valid <= 1'b0;
         end
         if (xfer_start) lane <= '0;
         else if (fire)  lane <= lane + 1'b1;
      end
   end

   // R9
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
   // R3
   dst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fill_simple || cfg_fill_mask || cfg_op == 3'd0 || cfg_op == 3'd4 || cfg_op == 3'd7)
      |-> !dst_ready);
   // R4
   src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fill_simple && !xfer_start) |-> !src_ready);
endmodule

// File: tb/fill_blend_dp_tb.sv
`timescale 1ns/1ps
module fill_blend_dp_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, xfer_start;
   logic [2:0] cfg_op;
   logic       cfg_fill_simple, cfg_fill_mask, cfg_mask_lsb, cfg_skip_en;
   logic [1:0] cfg_skip_n;
   logic [31:0] fill_one, fill_two;
   logic       src_valid, src_ready, dst_valid, dst_ready, wr_valid, wr_ready;
   logic [7:0] src_data, dst_data, wr_data;

   fill_blend_dp u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .cfg_op(cfg_op),
      .cfg_fill_simple(cfg_fill_simple), .cfg_fill_mask(cfg_fill_mask),
      .cfg_mask_lsb(cfg_mask_lsb), .cfg_skip_en(cfg_skip_en), .cfg_skip_n(cfg_skip_n),
      .fill_one(fill_one), .fill_two(fill_two),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(int i);
      return 8'((i * 73 + 29) % 256);
   endfunction
   function automatic logic [7:0] dbyte(int j);
      return 8'((j * 151 + 200) % 256) ^ 8'h5a;
   endfunction
   function automatic int kept_raw(int m);
      int n = 1 << cfg_skip_n;
      if (!cfg_skip_en) return m;
      return (m / n) * 2 * n + (m % n);
   endfunction
   function automatic logic [7:0] lane_of(logic [31:0] w, int k);
      return 8'(w >> (8 * (k % 4)));
   endfunction
   function automatic bit op_uses_d(logic [2:0] o);
      return (o == 1 || o == 2 || o == 3 || o == 5 || o == 6);
   endfunction

   function automatic logic [7:0] expect_byte(int k);
      logic [7:0] s, d, m;
      bit b;
      if (cfg_fill_simple) return lane_of(fill_one, k);
      if (cfg_fill_mask) begin
         m = sbyte(kept_raw(k / 8));
         b = cfg_mask_lsb ? m[k % 8] : m[7 - (k % 8)];
         return b ? lane_of(fill_one, k) : lane_of(fill_two, k);
      end
      s = sbyte(kept_raw(k));
      d = dbyte(k);
      case (cfg_op)
         3'd0: return s;
         3'd1: return s & d;
         3'd2: return s | d;
         3'd3: return s ^ d;
         3'd4: return ~s;
         3'd5: return s & ~d;
         3'd6: return s | ~d;
         default: return 8'h00;
      endcase
   endfunction

   task automatic run(string tag, bit simple, bit mask, bit lsb, bit skip,
                      logic [1:0] n, logic [2:0] op, int nout, bit stall);
      int sidx = 0, didx = 0, oidx = 0, cyc = 0;
      bit hold_pend = 0;
      logic [7:0] hold_data = 0;
      @(negedge clk);
      src_valid = 0; dst_valid = 0; wr_ready = 1;
      cfg_fill_simple = 0; cfg_fill_mask = 0; xfer_start = 0;
      repeat (3) @(negedge clk);
      cfg_fill_simple = simple; cfg_fill_mask = mask; cfg_mask_lsb = lsb;
      cfg_skip_en = skip; cfg_skip_n = n; cfg_op = op;
      xfer_start = 1;
      @(negedge clk);
      xfer_start = 0;
      while (oidx < nout && cyc < 3000 && !done) begin
         src_valid = 1; src_data = sbyte(sidx);
         dst_valid = 1; dst_data = dbyte(didx);
         wr_ready  = stall ? ((cyc % 3) != 1) : 1'b1;
         #1;
         if (hold_pend)
            chk(wr_valid && wr_data == hold_data, {tag, " R9 stall hold"}, int'(wr_data), int'(hold_data));
         hold_pend = wr_valid && !wr_ready;
         hold_data = wr_data;
         if (src_valid && src_ready) sidx++;
         if (dst_valid && dst_ready) didx++;
         if (wr_valid && wr_ready) begin
            chk(wr_data == expect_byte(oidx), tag, int'(wr_data), int'(expect_byte(oidx)));
            oidx++;
         end
         cyc++;
         @(negedge clk);
      end
      if (oidx < nout) chk(0, {tag, " output count"}, oidx, nout);
      if (simple || mask || !op_uses_d(op))
         chk(didx == 0, {tag, " R3 no destination read"}, didx, 0);
      if (simple)
         chk(sidx == 0, {tag, " R4 no source consumed"}, sidx, 0);
   endtask

   initial begin
      #(5ns * 100000);
      chk(0, "watchdog expired", 0, 1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; xfer_start = 0; cfg_op = 0; cfg_fill_simple = 0; cfg_fill_mask = 0;
      cfg_mask_lsb = 0; cfg_skip_en = 0; cfg_skip_n = 0;
      fill_one = 32'hA1B2C3D4; fill_two = 32'h0F1E2D3C;
      src_valid = 0; dst_valid = 0; wr_ready = 1; src_data = 0; dst_data = 0;
      repeat (3) @(negedge clk);
      chk(wr_valid == 0, "R1 wr_valid in reset", int'(wr_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk(wr_valid == 0 && dst_ready == 0, "R1 after reset", int'({wr_valid, dst_ready}), 0);

      for (int o = 0; o < 8; o++) begin
         run($sformatf("R2 op%0d", o), 0, 0, 0, 0, 2'd0, 3'(o), 24, 0);
         run($sformatf("R2 op%0d stalled", o), 0, 0, 0, 0, 2'd0, 3'(o), 20, 1);
      end
      for (int n = 0; n < 4; n++) begin
         run($sformatf("R8 blend skip n%0d", n), 0, 0, 0, 1, 2'(n), 3'd3, 40, 0);
         run($sformatf("R8 mask skip n%0d", n), 0, 1, 0, 1, 2'(n), 3'd0, 48, n % 2 == 1);
      end
      run("R4 constant fill", 1, 0, 0, 0, 2'd0, 3'd0, 12, 0);
      run("R4 constant fill stalled", 1, 0, 0, 1, 2'd1, 3'd1, 12, 1);
      run("R5 constant over mask", 1, 1, 1, 0, 2'd0, 3'd2, 12, 0);
      run("R6 mask msb first", 0, 1, 0, 0, 2'd0, 3'd1, 32, 0);
      run("R6 mask stalled", 0, 1, 0, 0, 2'd0, 3'd3, 24, 1);
      run("R7 mask lsb first", 0, 1, 1, 0, 2'd0, 3'd0, 32, 0);
      run("R10 partial mask", 0, 1, 0, 0, 2'd0, 3'd0, 5, 0);
      run("R10 mask after restart", 0, 1, 1, 0, 2'd0, 3'd0, 16, 0);
      run("R10 partial skip", 0, 0, 0, 1, 2'd2, 3'd0, 3, 0);
      run("R10 skip after restart", 0, 0, 0, 1, 2'd2, 3'd0, 12, 0);
      run("R10 partial lanes", 1, 0, 0, 0, 2'd0, 3'd0, 3, 0);
      run("R10 lanes after restart", 1, 0, 0, 0, 2'd0, 3'd0, 6, 0);

      if (!done) begin
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule